// File: doc/BRIEF.md
# Shared-Bus Central Arbiter

This block is the central arbiter of a PCI-style shared bus with up to nine masters. Each master has an active-low request line and receives an active-low grant line. The arbiter drives at most one grant at a time. It chooses the next owner by rotating round-robin priority. It tracks whether the bus is idle by watching FRAME# and IRDY#. It also enforces two tenure limits.

The first limit is a start timeout. A master that holds its grant on an idle bus but never begins a transaction loses the grant. The second limit is preemption. A master that keeps requesting while others wait loses its grant after a selectable delay. Both the preemption enable and the delay are static configuration inputs.

A grant handoff works differently on an idle bus and a busy bus. On an idle bus there is always one clock with no grant between two owners, so two devices never drive the bus in the same clock. On a busy bus the grant moves in a single clock. When nothing is requested, the grant stays on the last owner, so that device parks the bus.

Top module: `pci_bus_arbiter`

## Requirements
- R1: A synchronous active-high reset drives every grant high. The priority pointer is left so that the first grant after reset goes to the lowest-numbered requester.
- R2: At most one bit of `gnt_n` is low in any cycle.
- R3: When no grant is held and at least one request is sampled low, a grant is driven at that clock edge. It goes to the first requester found by searching upward from the last owner's index plus one, wrapping past the top index.
- R4: When every request is sampled high, the grant outputs do not change at that edge. This holds whether a grant is held or not.
- R5: The bus is idle when `frame_n` and `irdy_n` are both sampled high. Suppose the owner has released its request and another master is requesting while the bus is idle. Then the grant is dropped at that edge, and the next grant appears one edge later. No grant is raised at the same edge that drops another.
- R6: Suppose the owner must give up the bus while `frame_n` or `irdy_n` is sampled low. Then its grant moves to the next other requester at that same edge, with no gap.
- R7: Suppose the owner keeps its request low and the bus is sampled idle on every edge while it holds the grant. Then the grant is removed at the 16th such edge after it was raised, so the grant stays low for 16 clocks.
- R8: With `preempt_off` high, an owner that keeps requesting keeps its grant while other masters wait. With `preempt_off` low (the reset-default setting of the control), preemption is active.
- R9: `preempt_sel` codes 0 to 7 select a delay d of 0, 1, 2, 4, 8, 16, 32 or 64 clocks. Let the owner keep requesting, with preemption active. If another request is first sampled low at edge k and stays low, the owner's grant is removed at edge k+d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | N_MASTERS | Per-master bus request, active low |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| preempt_off | input | 1 | 1 disables preemption; 0 enables it |
| preempt_sel | input | 3 | Time-to-preempt code (0..7 maps to 0,1,2,4,...,64 clocks) |
| gnt_n | output | N_MASTERS | Per-master bus grant, active low |

## Verification
The preemption expiry and the start timeout can fall on the same edge. This happens when a requesting owner sits on an idle bus with another master waiting. When it does, the arbiter must take the grant back exactly once and leave the one-clock gap.

The random phase provokes this coincidence. It mixes long idle stretches with waiting requesters, and it cycles the time-to-preempt code so that the 16-clock timeout and the preemption delay line up. Every cycle, a bench model built from the requirements judges the grant vector: the grant must drop once, and the next grant must appear only after a clock with no grant. Directed steps pin the exact edge of each kind of handoff, of the timeout and of a 4-clock preemption.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

    localparam int TTP_CODE_W = 3;
    localparam int TTP_CNT_W  = 7;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_GRANT,
        ACT_SWITCH,
        ACT_YIELD,
        ACT_TIMEOUT
    } arb_act_e;

    // Time-to-preempt decode: 0 -> 0 clocks, n -> 2^(n-1) clocks
    function automatic logic [TTP_CNT_W-1:0] ttp_cycles(input logic [TTP_CODE_W-1:0] code);
        logic [TTP_CNT_W-1:0] r;
        if (code == '0)
            r = '0;
        else
            r = TTP_CNT_W'(1) << (code - TTP_CODE_W'(1));
        return r;
    endfunction

endpackage

// File: rtl/pci_arb_rr_pick.sv
module pci_arb_rr_pick #(
    parameter int N  = 9,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] sel
);
    // Search starts one above the last owner and wraps; the last owner comes last
    always_comb begin
        logic [IW:0] j;
        found = 1'b0;
        sel   = last;
        for (int i = 1; i <= N; i++) begin
            j = {1'b0, last} + (IW+1)'(i);
            if (j >= (IW+1)'(N))
                j = j - (IW+1)'(N);
            if (!found && req[IW'(j)]) begin
                found = 1'b1;
                sel   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/pci_arb_timer.sv
module pci_arb_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Saturating up-counter, clear wins over increment
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && (cnt != {W{1'b1}}))
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/pci_bus_arbiter.sv
module pci_bus_arbiter
    import pci_arb_pkg::*;
#(
    parameter int N_MASTERS  = 9,
    parameter int IDLE_LIMIT = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_MASTERS-1:0]  req_n,
    input  logic                  frame_n,
    input  logic                  irdy_n,
    input  logic                  preempt_off,
    input  logic [2:0]            preempt_sel,
    output logic [N_MASTERS-1:0]  gnt_n
);
    localparam int IW     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
    localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);

    typedef struct packed {
        logic          on;
        logic [IW-1:0] owner;
    } grant_st_t;

    grant_st_t st_q, st_d;
    arb_act_e  act;

    logic [N_MASTERS-1:0] req_act, own_mask, others;
    logic                 bus_idle, owner_req, others_any;
    logic                 all_found, oth_found;
    logic [IW-1:0]        all_sel, oth_sel;
    logic [IDLE_W-1:0]    idle_cnt;
    logic [TTP_CNT_W-1:0] wait_cnt, ttp_lim;
    logic                 pre_hit, idle_cond, wait_cond, changed;

    assign bus_idle   = frame_n & irdy_n;
    assign req_act    = ~req_n;
    assign own_mask   = N_MASTERS'(1) << st_q.owner;
    assign owner_req  = |(req_act & own_mask);
    assign others     = req_act & ~own_mask;
    assign others_any = |others;
    assign ttp_lim    = ttp_cycles(preempt_sel);
    assign pre_hit    = !preempt_off && (wait_cnt >= ttp_lim);

    // Candidate when the bus is free
    pci_arb_rr_pick #(.N(N_MASTERS), .IW(IW)) u_pick_all (
        .req   (req_act),
        .last  (st_q.owner),
        .found (all_found),
        .sel   (all_sel)
    );

    // Candidate excluding the current owner (busy-bus handoff)
    pci_arb_rr_pick #(.N(N_MASTERS), .IW(IW)) u_pick_oth (
        .req   (others),
        .last  (st_q.owner),
        .found (oth_found),
        .sel   (oth_sel)
    );

    always_comb begin
        act = ACT_HOLD;
        if (!st_q.on) begin
            if (all_found)
                act = ACT_GRANT;
        end else if (others_any && (!owner_req || pre_hit)) begin
            act = bus_idle ? ACT_YIELD : ACT_SWITCH;
        end else if (owner_req && bus_idle &&
                     (idle_cnt == IDLE_W'(IDLE_LIMIT - 1))) begin
            act = ACT_TIMEOUT;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_GRANT:   begin st_d.on = 1'b1; st_d.owner = all_sel; end
            ACT_SWITCH:  begin st_d.owner = oth_found ? oth_sel : st_q.owner; end
            ACT_YIELD,
            ACT_TIMEOUT: begin st_d.on = 1'b0; end
            default:     ;
        endcase
    end

    assign changed   = (act != ACT_HOLD);
    assign idle_cond = st_q.on && owner_req && bus_idle;
    assign wait_cond = st_q.on && owner_req && others_any && !preempt_off;

    pci_arb_timer #(.W(IDLE_W)) u_idle_tmr (
        .clk (clk),
        .rst (rst),
        .clr (changed || !idle_cond),
        .inc (idle_cond),
        .cnt (idle_cnt)
    );

    pci_arb_timer #(.W(TTP_CNT_W)) u_wait_tmr (
        .clk (clk),
        .rst (rst),
        .clr (changed || !wait_cond),
        .inc (wait_cond),
        .cnt (wait_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.on    <= 1'b0;
            st_q.owner <= IW'(N_MASTERS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_n = st_q.on ? ~own_mask : '1;

endmodule

// File: rtl/pci_bus_arbiter_chk.sv
module pci_bus_arbiter_chk #(
    parameter int N_MASTERS = 9
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_MASTERS-1:0] req_n,
    input logic                 frame_n,
    input logic                 irdy_n,
    input logic [N_MASTERS-1:0] gnt_n
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (&gnt_n));

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~gnt_n));

    // R3
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        ((&$past(gnt_n)) && !(&gnt_n)) |-> (((~gnt_n) & $past(req_n)) == '0));

    // R4
    park_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (&req_n) |=> $stable(gnt_n));

    // R5
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!(&$past(gnt_n)) && !(&gnt_n) && (gnt_n != $past(gnt_n)))
            |-> !($past(frame_n) && $past(irdy_n)));
endmodule

bind pci_bus_arbiter pci_bus_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_n   (req_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .gnt_n   (gnt_n)
);

// File: tb/pci_bus_arbiter_tb.sv
module pci_bus_arbiter_tb;
    localparam int N = 9;
    localparam logic [N-1:0] NONE = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_n = '1;
    logic         frame_n = 1'b1;
    logic         irdy_n = 1'b1;
    logic         preempt_off = 1'b0;
    logic [2:0]   preempt_sel = 3'd0;
    logic [N-1:0] gnt_n;

    int total = 0;
    int bad = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pci_bus_arbiter #(.N_MASTERS(N), .IDLE_LIMIT(16)) u_dut (
        .clk(clk), .rst(rst), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .preempt_off(preempt_off), .preempt_sel(preempt_sel), .gnt_n(gnt_n)
    );

    function automatic logic [N-1:0] g(input int i);
        return ~(N'(1) << i);
    endfunction

    function automatic int delay_of(input logic [2:0] c);
        return (c == 3'd0) ? 0 : (1 << (int'(c) - 1));
    endfunction

    function automatic int rr_next(input logic [N-1:0] rq, input int last);
        for (int i = 1; i <= N; i++) begin
            if (rq[(last + i) % N]) return (last + i) % N;
        end
        return last;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: gnt_n actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference model written from the requirements
    bit m_on;
    int m_own, m_idle, m_wait;
    always @(posedge clk) begin
        if (rst) begin
            m_on = 1'b0; m_own = N - 1; m_idle = 0; m_wait = 0;
        end else begin
            logic [N-1:0] rq, oth;
            bit idle, oreq, chg, was_on;
            rq = ~req_n; idle = frame_n && irdy_n; chg = 1'b0; was_on = m_on;
            oreq = rq[m_own]; oth = rq & ~(N'(1) << m_own);
            if (!m_on) begin
                if (rq != '0) begin m_own = rr_next(rq, m_own); m_on = 1'b1; chg = 1'b1; end
            end else if (oth != '0 && (!oreq || (!preempt_off && m_wait >= delay_of(preempt_sel)))) begin
                chg = 1'b1;
                if (idle) m_on = 1'b0; else m_own = rr_next(oth, m_own);
            end else if (oreq && idle && m_idle == 15) begin
                chg = 1'b1; m_on = 1'b0;
            end
            if (chg || !was_on) begin m_idle = 0; m_wait = 0; end
            else begin
                m_idle = (oreq && idle) ? m_idle + 1 : 0;
                m_wait = (oreq && oth != '0 && !preempt_off) ? ((m_wait < 127) ? m_wait + 1 : 127) : 0;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_en && !rst) begin
            chk("model R3,R5,R6,R7,R9", gnt_n, m_on ? g(m_own) : NONE);
            total++;
            if ($countones(~gnt_n) > 1) begin
                bad++;
                $display("FAIL R2: low grants actual=%0d expected<=1", $countones(~gnt_n));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset", gnt_n, NONE);
        // R1/R3: first grant after reset goes to lowest requester
        rst = 1'b0; preempt_off = 1'b1; mon_en = 1'b1;
        req_n = g(2) & g(5);
        @(negedge clk);
        chk("R1 first grant", gnt_n, g(2));
        // R5: owner releases on idle bus -> one gap clock
        req_n = g(5);
        @(negedge clk); chk("R5 drop", gnt_n, NONE);
        @(negedge clk); chk("R5 next", gnt_n, g(5));
        // R7: start timeout after 16 idle clocks
        for (int i = 1; i < 16; i++) begin
            @(negedge clk); chk("R7 held", gnt_n, g(5));
        end
        @(negedge clk); chk("R7 revoke", gnt_n, NONE);
        @(negedge clk); chk("R3 regrant", gnt_n, g(5));
        // R6: busy bus handoff in one clock
        frame_n = 1'b0; req_n = g(1);
        @(negedge clk); chk("R6 switch", gnt_n, g(1));
        // R4: parking with no requests
        req_n = NONE; frame_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); chk("R4 park", gnt_n, g(1));
        end
        // R9: code 3 -> 4 clocks
        preempt_off = 1'b0; preempt_sel = 3'd3; frame_n = 1'b0; req_n = g(1);
        @(negedge clk); chk("R9 own", gnt_n, g(1));
        req_n = g(1) & g(7);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); chk("R9 wait", gnt_n, g(1));
        end
        @(negedge clk); chk("R9 preempt", gnt_n, g(7));
        // R8: preemption disabled
        preempt_off = 1'b1; req_n = g(7) & g(0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); chk("R8 no preempt", gnt_n, g(7));
        end
        // R9 code 0: immediate
        preempt_off = 1'b0; preempt_sel = 3'd0;
        @(negedge clk); chk("R9 code0", gnt_n, g(0));
        // Random phase
        begin
            int busy_pct;
            busy_pct = 30;
            for (int c = 0; c < 6000; c++) begin
                @(negedge clk);
                if (c % 100 == 0) begin
                    busy_pct = ($urandom % 3) * 35;
                    preempt_off = ($urandom % 5 == 0);
                    preempt_sel = 3'($urandom % 8);
                end
                if ($urandom % 4 == 0) begin
                    for (int b = 0; b < N; b++)
                        req_n[b] = ($urandom % 10 < 3) ? 1'b0 : 1'b1;
                end
                frame_n = ($urandom % 100 < busy_pct) ? 1'b0 : 1'b1;
                irdy_n  = ($urandom % 100 < busy_pct / 2) ? 1'b0 : 1'b1;
            end
        end
        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk); chk("R1 reset again", gnt_n, NONE);
        mon_en = 1'b0; done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule